// File: doc/BRIEF.md
# Receive Frame Length and FCS Policer

This block sits on the user-side receive stream of a 10G/25G Ethernet MAC, after the preamble and start delimiter have been removed. Each beat carries eight bytes with a contiguous keep mask that starts at byte 0. Start-of-packet and end-of-packet markers frame each packet. A two-bit FCS verdict, computed upstream, arrives on the end-of-packet beat.

The block counts the bytes of every frame. Frames longer than a programmed ceiling are cut short, and everything after the cut point is thrown away. Frames shorter than a programmed floor are marked. The block applies the FCS verdict to the error flag, and can remove the four trailing FCS bytes. Fragments too short to be frames are dropped. One-cycle pulses report truncations, bad FCS values and stomped FCS values, for use by statistics logic elsewhere. A live enable input admits or refuses frames only at their first beat.

Top module: `rx_len_policer`

## Requirements
- R1: The ceiling, floor, FCS removal and FCS ignore controls are captured only while `rst` is high. Changing them after reset has no effect on how frames are handled.
- R2: A frame that is within the limits, has a good FCS and has FCS removal off is delivered byte for byte, in order, with `out_err` low.
- R3: A frame whose byte count exceeds the ceiling is delivered as exactly ceiling bytes. Its last beat carries `out_eop` and `out_err`. The remaining input beats of that frame are discarded, and the next start-of-packet is handled normally.
- R4: Each truncation raises `trunc_pulse` for exactly one cycle. The truncated last beat appears on the output in the following cycle.
- R5: A delivered frame whose received length, FCS included, is below the floor has `out_err` set on its end-of-packet beat. A frame whose length equals the floor does not.
- R6: A frame of fewer than 4 bytes produces no output beat and no FCS pulse.
- R7: With FCS removal on, a frame of more than 8 bytes loses its last 4 bytes, even when those bytes straddle two beats. A frame of 8 bytes or fewer keeps all its bytes.
- R8: The FCS verdict uses 2'b00 for good, 2'b10 for stomped, and any other value for bad. With FCS ignore off, a bad or stomped verdict sets `out_err`. With FCS ignore on, the verdict never sets `out_err`.
- R9: A bad verdict raises `bad_fcs_pulse` for one cycle, and a stomped verdict raises `stomp_fcs_pulse` for one cycle. The two never appear together. Both pulses appear whatever the FCS ignore setting.
- R10: `cfg_enable` is examined only at a start-of-packet beat. A frame that starts while it is low produces no output. A frame that started while it was high is delivered whole even if it drops mid-frame.
- R11: On the output, every beat without end-of-packet has all eight keep bits set. Every keep mask is non-zero and contiguous from byte 0. Every frame begins with `out_sop` and ends with `out_eop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; controls are captured while high |
| cfg_enable | input | 1 | Live admission enable, checked at start-of-packet |
| cfg_max_len | input | 15 | Length ceiling in bytes, 64 to 16383 |
| cfg_min_len | input | 8 | Length floor in bytes |
| cfg_strip_fcs | input | 1 | Remove the trailing 4 FCS bytes |
| cfg_ignore_fcs | input | 1 | Keep the FCS verdict out of the error flag |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 64 | Input bytes, byte 0 in bits 7:0 |
| in_keep | input | 8 | Input byte valid mask |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_fcs | input | 2 | FCS verdict, valid with `in_eop` |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 64 | Output bytes |
| out_keep | output | 8 | Output byte valid mask |
| out_sop | output | 1 | First output beat of a frame |
| out_eop | output | 1 | Last output beat of a frame |
| out_err | output | 1 | Frame error, meaningful with `out_eop` |
| trunc_pulse | output | 1 | One-cycle truncation indicator |
| bad_fcs_pulse | output | 1 | One-cycle bad FCS indicator |
| stomp_fcs_pulse | output | 1 | One-cycle stomped FCS indicator |

## Verification
The assertions assume a well-formed input stream. Every beat without end-of-packet is full, keep masks are contiguous from byte 0, and a frame of more than 8 bytes therefore spans at least two beats. The assertions also assume a legal ceiling of at least 64, which is larger than one beat. The straddle check relies on all of this, because it expects a held, unfinished beat whenever an FCS split across beats is seen. The stimulus builds every frame from a length alone: it emits full beats and a final partial beat, holds `in_valid` low during reset, and programs only legal ceilings.

// File: rtl/rxlp_pkg.sv
package rxlp_pkg;

    localparam int BEAT_BYTES   = 8;
    localparam int DATA_W       = BEAT_BYTES * 8;
    localparam int CNT_W        = $clog2(BEAT_BYTES + 1) + 1;
    localparam int LEN_W        = 15;
    localparam int MIN_W        = 8;
    localparam int FCS_BYTES    = 4;
    localparam int RUNT_LIMIT   = 4;
    localparam int SHORT_KEEP   = 8;

    typedef enum logic [1:0] {
        FCS_GOOD  = 2'b00,
        FCS_BAD   = 2'b01,
        FCS_STOMP = 2'b10,
        FCS_OTHER = 2'b11
    } fcs_e;

    typedef struct packed {
        logic [DATA_W-1:0]     data;
        logic [BEAT_BYTES-1:0] keep;
        logic                  sop;
        logic                  eop;
        logic                  err;
    } beat_t;

    typedef struct packed {
        logic [LEN_W-1:0] max_len;
        logic [MIN_W-1:0] min_len;
        logic             strip_fcs;
        logic             ignore_fcs;
    } cfg_t;

    function automatic logic [CNT_W-1:0] keep_count(input logic [BEAT_BYTES-1:0] k);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < BEAT_BYTES; i++) begin
            n = n + CNT_W'(k[i]);
        end
        return n;
    endfunction

    function automatic logic [BEAT_BYTES-1:0] count_to_keep(input logic [CNT_W-1:0] n);
        logic [BEAT_BYTES-1:0] m;
        for (int i = 0; i < BEAT_BYTES; i++) begin
            m[i] = (CNT_W'(i) < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/rxlp_admit.sv
module rxlp_admit
    import rxlp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  cfg_t                  cfg,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [BEAT_BYTES-1:0] in_keep,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic [1:0]            in_fcs,
    output logic                  adm_valid,
    output beat_t                 adm_beat,
    output logic                  adm_strip,
    output logic                  adm_close,
    output logic                  trunc_pulse,
    output logic                  bad_pulse,
    output logic                  stomp_pulse
);

    logic [LEN_W-1:0] cnt_q, cnt_n;
    logic             busy_q, busy_n;
    logic             trunc_n, bad_n, stomp_n;
    logic [LEN_W:0]   base, tot, rem, max_w;
    logic             take, runt, over;
    fcs_e             verdict;

    assign verdict = fcs_e'(in_fcs);
    assign max_w   = {1'b0, cfg.max_len};
    assign base    = in_sop ? '0 : {1'b0, cnt_q};
    assign tot     = base + (LEN_W+1)'(keep_count(in_keep));
    assign rem     = max_w - base;
    assign take    = in_valid && (in_sop ? enable : busy_q);
    assign runt    = in_sop && in_eop && (tot < (LEN_W+1)'(RUNT_LIMIT));
    assign over    = tot > max_w;

    always_comb begin
        adm_valid     = 1'b0;
        adm_close     = 1'b0;
        adm_strip     = 1'b0;
        adm_beat.data = in_data;
        adm_beat.keep = in_keep;
        adm_beat.sop  = in_sop;
        adm_beat.eop  = in_eop;
        adm_beat.err  = 1'b0;
        trunc_n       = 1'b0;
        bad_n         = 1'b0;
        stomp_n       = 1'b0;
        cnt_n         = cnt_q;
        busy_n        = busy_q;
        if (in_valid && in_sop) begin
            busy_n = 1'b0;
        end
        if (take) begin
            if (runt) begin
                busy_n = 1'b0;
            end else if (over) begin
                trunc_n = 1'b0 | 1'b1;
                busy_n  = 1'b0;
                cnt_n   = cfg.max_len;
                if (rem == '0) begin
                    adm_close = 1'b1;
                end else begin
                    adm_valid     = 1'b1;
                    adm_beat.keep = count_to_keep(CNT_W'(rem));
                    adm_beat.eop  = 1'b1;
                    adm_beat.err  = 1'b1;
                end
            end else begin
                adm_valid = 1'b1;
                cnt_n     = tot[LEN_W-1:0];
                busy_n    = !in_eop;
                if (in_eop) begin
                    stomp_n      = (verdict == FCS_STOMP);
                    bad_n        = (verdict == FCS_BAD) || (verdict == FCS_OTHER);
                    adm_beat.err = (tot < (LEN_W+1)'(cfg.min_len))
                                 || ((bad_n || stomp_n) && !cfg.ignore_fcs);
                    adm_strip    = cfg.strip_fcs && (tot > (LEN_W+1)'(SHORT_KEEP));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            busy_q      <= 1'b0;
            trunc_pulse <= 1'b0;
            bad_pulse   <= 1'b0;
            stomp_pulse <= 1'b0;
        end else begin
            cnt_q       <= cnt_n;
            busy_q      <= busy_n;
            trunc_pulse <= trunc_n;
            bad_pulse   <= bad_n;
            stomp_pulse <= stomp_n;
        end
    end

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= cfg.max_len) else $error("count above ceiling"); // R3

    AST_RUNT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && in_eop && enable && (keep_count(in_keep) < CNT_W'(RUNT_LIMIT)))
        |=> (!bad_pulse && !stomp_pulse)) else $error("runt reported"); // R6

endmodule

// File: rtl/rxlp_fcs_trim.sv
module rxlp_fcs_trim
    import rxlp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adm_valid,
    input  beat_t adm_beat,
    input  logic  adm_strip,
    input  logic  adm_close,
    output logic  out_valid,
    output beat_t out_beat
);

    beat_t            pend_q, pend_n, emit_beat;
    logic             pend_v_q, pend_v_n, emit;
    logic [CNT_W-1:0] kp, ka;
    logic             straddle;

    assign kp       = keep_count(pend_q.keep);
    assign ka       = keep_count(adm_beat.keep);
    assign straddle = adm_valid && adm_strip && (ka <= CNT_W'(FCS_BYTES));

    always_comb begin
        emit      = 1'b0;
        emit_beat = pend_q;
        pend_n    = pend_q;
        pend_v_n  = pend_v_q;
        if (adm_close) begin
            pend_n.eop = 1'b1;
            pend_n.err = 1'b1;
        end else if (adm_valid) begin
            emit = pend_v_q;
            if (straddle) begin
                emit_beat.keep = count_to_keep(kp + ka - CNT_W'(FCS_BYTES));
                emit_beat.eop  = 1'b1;
                emit_beat.err  = adm_beat.err;
                pend_v_n       = 1'b0;
            end else begin
                pend_v_n = 1'b1;
                pend_n   = adm_beat;
                if (adm_strip) begin
                    pend_n.keep = count_to_keep(ka - CNT_W'(FCS_BYTES));
                end
            end
        end else if (pend_v_q && pend_q.eop) begin
            emit     = 1'b1;
            pend_v_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v_q  <= 1'b0;
            pend_q    <= '0;
            out_valid <= 1'b0;
            out_beat  <= '0;
        end else begin
            pend_v_q  <= pend_v_n;
            pend_q    <= pend_n;
            out_valid <= emit;
            out_beat  <= emit ? emit_beat : out_beat;
        end
    end

    AST_KEEP_SHAPE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_beat.keep != '0) && ((out_beat.keep & (out_beat.keep + 1'b1)) == '0)))
        else $error("bad keep shape"); // R11

    AST_FULL_MID: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_beat.eop) |-> (&out_beat.keep)) else $error("partial mid beat"); // R11

    AST_STRADDLE_HELD: assert property (@(posedge clk) disable iff (rst)
        straddle |-> (pend_v_q && !pend_q.eop)) else $error("straddle without held beat"); // R7

endmodule

// File: rtl/rx_len_policer.sv
module rx_len_policer
    import rxlp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_enable,
    input  logic [LEN_W-1:0]      cfg_max_len,
    input  logic [MIN_W-1:0]      cfg_min_len,
    input  logic                  cfg_strip_fcs,
    input  logic                  cfg_ignore_fcs,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [BEAT_BYTES-1:0] in_keep,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic [1:0]            in_fcs,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    output logic [BEAT_BYTES-1:0] out_keep,
    output logic                  out_sop,
    output logic                  out_eop,
    output logic                  out_err,
    output logic                  trunc_pulse,
    output logic                  bad_fcs_pulse,
    output logic                  stomp_fcs_pulse
);

    cfg_t  cfg_q;
    beat_t adm_beat, out_beat;
    logic  adm_valid, adm_strip, adm_close;
    logic  out_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.max_len    <= cfg_max_len;
            cfg_q.min_len    <= cfg_min_len;
            cfg_q.strip_fcs  <= cfg_strip_fcs;
            cfg_q.ignore_fcs <= cfg_ignore_fcs;
        end
    end

    rxlp_admit u_admit (
        .clk         (clk),
        .rst         (rst),
        .enable      (cfg_enable),
        .cfg         (cfg_q),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_keep     (in_keep),
        .in_sop      (in_sop),
        .in_eop      (in_eop),
        .in_fcs      (in_fcs),
        .adm_valid   (adm_valid),
        .adm_beat    (adm_beat),
        .adm_strip   (adm_strip),
        .adm_close   (adm_close),
        .trunc_pulse (trunc_pulse),
        .bad_pulse   (bad_fcs_pulse),
        .stomp_pulse (stomp_fcs_pulse)
    );

    rxlp_fcs_trim u_trim (
        .clk       (clk),
        .rst       (rst),
        .adm_valid (adm_valid),
        .adm_beat  (adm_beat),
        .adm_strip (adm_strip),
        .adm_close (adm_close),
        .out_valid (out_valid),
        .out_beat  (out_beat)
    );

    assign out_data = out_beat.data;
    assign out_keep = out_beat.keep;
    assign out_sop  = out_beat.sop;
    assign out_eop  = out_beat.eop;
    assign out_err  = out_beat.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_open <= 1'b0;
        end else if (out_valid) begin
            out_open <= !out_eop;
        end
    end

    AST_TRUNC_LAST: assert property (@(posedge clk) disable iff (rst)
        trunc_pulse |=> (out_valid && out_eop && out_err)) else $error("truncation not closed"); // R4

    AST_SOP_ORDER: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sop == !out_open)) else $error("framing broken"); // R11

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bad_fcs_pulse && stomp_fcs_pulse)) else $error("both fcs pulses"); // R9

    AST_QUIET_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(in_valid)) |=> !out_valid) else $error("output without input"); // R10

endmodule

// File: tb/rx_len_policer_tb.sv
module rx_len_policer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b1;
    logic [14:0] cfg_max_len = 15'd1518;
    logic [7:0]  cfg_min_len = 8'd0;
    logic        cfg_strip_fcs = 1'b0;
    logic        cfg_ignore_fcs = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_keep = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [1:0]  in_fcs = 2'b00;
    logic        out_valid, out_sop, out_eop, out_err;
    logic [63:0] out_data;
    logic [7:0]  out_keep;
    logic        trunc_pulse, bad_fcs_pulse, stomp_fcs_pulse;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_len_policer u_dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_max_len(cfg_max_len),
        .cfg_min_len(cfg_min_len), .cfg_strip_fcs(cfg_strip_fcs), .cfg_ignore_fcs(cfg_ignore_fcs),
        .in_valid(in_valid), .in_data(in_data), .in_keep(in_keep), .in_sop(in_sop),
        .in_eop(in_eop), .in_fcs(in_fcs), .out_valid(out_valid), .out_data(out_data),
        .out_keep(out_keep), .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
        .trunc_pulse(trunc_pulse), .bad_fcs_pulse(bad_fcs_pulse), .stomp_fcs_pulse(stomp_fcs_pulse)
    );

    int f_len[$];
    int f_err[$];
    int f_first[$];
    int f_mism[$];
    int cur_len, cur_first, cur_mism;
    int trunc_n, bad_n, stomp_n, trunc_run, trunc_max_run;
    int partial_n = 0;
    int shape_n = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (trunc_pulse) begin
                trunc_n++;
                trunc_run++;
                if (trunc_run > trunc_max_run) trunc_max_run = trunc_run;
            end else begin
                trunc_run = 0;
            end
            if (bad_fcs_pulse) bad_n++;
            if (stomp_fcs_pulse) stomp_n++;
            if (out_valid) begin
                if (out_sop) begin
                    cur_len = 0;
                    cur_first = int'(out_data[7:0]);
                    cur_mism = 0;
                end
                if (out_keep == 8'h00 || ((out_keep & (out_keep + 8'h01)) != 8'h00)) shape_n++;
                if (!out_eop && out_keep != 8'hFF) partial_n++;
                for (int j = 0; j < 8; j++) begin
                    if (out_keep[j]) begin
                        if (out_data[j*8 +: 8] != 8'(cur_first + cur_len)) cur_mism++;
                        cur_len++;
                    end
                end
                if (out_eop) begin
                    f_len.push_back(cur_len);
                    f_err.push_back(int'(out_err));
                    f_first.push_back(cur_first);
                    f_mism.push_back(cur_mism);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        f_len.delete(); f_err.delete(); f_first.delete(); f_mism.delete();
        trunc_n = 0; bad_n = 0; stomp_n = 0; trunc_run = 0; trunc_max_run = 0;
    endtask

    task automatic do_reset(input int mx, input int mn, input bit strip, input bit ign);
        @(negedge clk);
        cfg_max_len = 15'(mx); cfg_min_len = 8'(mn);
        cfg_strip_fcs = strip; cfg_ignore_fcs = ign;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_obs();
    endtask

    task automatic send_frame(input int len, input int first, input logic [1:0] fcs,
                              input int drop_at, input bit hold);
        int nb;
        nb = (len + 7) / 8;
        for (int b = 0; b < nb; b++) begin
            int n;
            @(negedge clk);
            if (b == drop_at) cfg_enable = 1'b0;
            n = (len - b * 8 > 8) ? 8 : len - b * 8;
            in_valid = 1'b1;
            in_sop = (b == 0);
            in_eop = (b == nb - 1);
            in_keep = 8'((1 << n) - 1);
            for (int j = 0; j < 8; j++) in_data[j*8 +: 8] = 8'(first + b * 8 + j);
            in_fcs = (b == nb - 1) ? fcs : 2'b00;
        end
        if (!hold) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_fcs = 2'b00;
        end
    endtask

    task automatic settle();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_one(input string tag, input int len, input int err, input int first);
        check(f_len.size() == 1, {tag, " frame count"}, f_len.size(), 1);
        if (f_len.size() == 1) begin
            check(f_len[0] == len, {tag, " length"}, f_len[0], len);
            check(f_err[0] == err, {tag, " error flag"}, f_err[0], err);
            check(f_first[0] == first && f_mism[0] == 0, {tag, " byte content"}, f_mism[0], 0);
        end
    endtask

    task automatic t_reset_state();
        check(out_valid == 1'b0, "R2 reset out_valid", int'(out_valid), 0);
        check(!trunc_pulse && !bad_fcs_pulse && !stomp_fcs_pulse, "R9 reset pulses",
              int'(trunc_pulse) + int'(bad_fcs_pulse) + int'(stomp_fcs_pulse), 0);
    endtask

    task automatic t_plain();
        do_reset(1518, 0, 1'b0, 1'b0);
        send_frame(100, 5, 2'b00, -1, 1'b0); settle();
        expect_one("R2 plain 100", 100, 0, 5);
        clear_obs();
        send_frame(64, 40, 2'b00, -1, 1'b0); settle();
        expect_one("R2 plain 64", 64, 0, 40);
        check(trunc_n == 0, "R4 no truncation in limit", trunc_n, 0);
    endtask

    task automatic t_truncate();
        do_reset(100, 0, 1'b0, 1'b0);
        send_frame(130, 0, 2'b00, -1, 1'b0); settle();
        expect_one("R3 cut mid beat", 100, 1, 0);
        check(trunc_n == 1, "R4 pulse count", trunc_n, 1);
        check(trunc_max_run == 1, "R4 pulse width", trunc_max_run, 1);
        clear_obs();
        send_frame(70, 9, 2'b00, -1, 1'b0); settle();
        expect_one("R3 next frame after cut", 70, 0, 9);
        do_reset(96, 0, 1'b0, 1'b0);
        send_frame(120, 3, 2'b00, -1, 1'b0); settle();
        expect_one("R3 cut on beat edge", 96, 1, 3);
        check(trunc_n == 1, "R4 pulse on beat edge", trunc_n, 1);
        clear_obs();
        send_frame(96, 7, 2'b01, -1, 1'b0); settle();
        expect_one("R3 exactly ceiling", 96, 1, 7);
        check(trunc_n == 0, "R4 no pulse at ceiling", trunc_n, 0);
    endtask

    task automatic t_minimum();
        do_reset(1518, 64, 1'b0, 1'b0);
        send_frame(60, 1, 2'b00, -1, 1'b0); settle();
        expect_one("R5 below floor", 60, 1, 1);
        clear_obs();
        send_frame(64, 2, 2'b00, -1, 1'b0); settle();
        expect_one("R5 at floor", 64, 0, 2);
    endtask

    task automatic t_runt();
        do_reset(1518, 0, 1'b0, 1'b0);
        send_frame(3, 11, 2'b01, -1, 1'b0); settle();
        check(f_len.size() == 0, "R6 runt dropped", f_len.size(), 0);
        check(bad_n == 0, "R6 runt no pulse", bad_n, 0);
        send_frame(4, 12, 2'b00, -1, 1'b0); settle();
        expect_one("R6 four bytes kept", 4, 0, 12);
    endtask

    task automatic t_strip();
        do_reset(1518, 0, 1'b1, 1'b0);
        send_frame(100, 0, 2'b00, -1, 1'b0); settle();
        expect_one("R7 strip 100", 96, 0, 0);
        clear_obs();
        send_frame(98, 1, 2'b00, -1, 1'b0); settle();
        expect_one("R7 strip straddle 98", 94, 0, 1);
        clear_obs();
        send_frame(70, 2, 2'b00, -1, 1'b0); settle();
        expect_one("R7 strip in beat 70", 66, 0, 2);
        clear_obs();
        send_frame(9, 3, 2'b00, -1, 1'b0); settle();
        expect_one("R7 strip 9", 5, 0, 3);
        clear_obs();
        send_frame(12, 4, 2'b00, -1, 1'b0); settle();
        expect_one("R7 strip 12", 8, 0, 4);
        clear_obs();
        send_frame(8, 5, 2'b00, -1, 1'b0); settle();
        expect_one("R7 short kept 8", 8, 0, 5);
    endtask

    task automatic t_fcs();
        do_reset(1518, 0, 1'b0, 1'b0);
        send_frame(70, 0, 2'b01, -1, 1'b0); settle();
        expect_one("R8 bad flagged", 70, 1, 0);
        check(bad_n == 1 && stomp_n == 0, "R9 bad pulse", bad_n * 10 + stomp_n, 10);
        clear_obs();
        send_frame(70, 1, 2'b10, -1, 1'b0); settle();
        expect_one("R8 stomp flagged", 70, 1, 1);
        check(stomp_n == 1 && bad_n == 0, "R9 stomp pulse", bad_n * 10 + stomp_n, 1);
        do_reset(1518, 0, 1'b0, 1'b1);
        send_frame(70, 2, 2'b01, -1, 1'b0); settle();
        expect_one("R8 bad ignored", 70, 0, 2);
        check(bad_n == 1, "R9 pulse when ignored", bad_n, 1);
    endtask

    task automatic t_enable();
        do_reset(1518, 0, 1'b0, 1'b0);
        cfg_enable = 1'b0;
        send_frame(70, 0, 2'b00, -1, 1'b0); settle();
        check(f_len.size() == 0, "R10 refused while low", f_len.size(), 0);
        cfg_enable = 1'b1;
        send_frame(70, 6, 2'b00, 3, 1'b0); settle();
        expect_one("R10 finish after drop", 70, 0, 6);
        clear_obs();
        send_frame(40, 8, 2'b00, -1, 1'b0); settle();
        check(f_len.size() == 0, "R10 idle after drop", f_len.size(), 0);
        cfg_enable = 1'b1;
    endtask

    task automatic t_latch();
        do_reset(100, 0, 1'b0, 1'b0);
        @(negedge clk);
        cfg_max_len = 15'd2000; cfg_strip_fcs = 1'b1; cfg_min_len = 8'd200;
        send_frame(130, 0, 2'b00, -1, 1'b0); settle();
        expect_one("R1 controls held", 100, 1, 0);
    endtask

    task automatic t_burst();
        do_reset(1518, 0, 1'b0, 1'b0);
        send_frame(20, 10, 2'b00, -1, 1'b1);
        send_frame(70, 50, 2'b00, -1, 1'b1);
        send_frame(5, 90, 2'b00, -1, 1'b0);
        settle();
        check(f_len.size() == 3, "R2 burst frame count", f_len.size(), 3);
        if (f_len.size() == 3) begin
            check(f_len[0] == 20 && f_first[0] == 10, "R2 burst first", f_len[0], 20);
            check(f_len[1] == 70 && f_first[1] == 50, "R2 burst second", f_len[1], 70);
            check(f_len[2] == 5 && f_first[2] == 90, "R2 burst third", f_len[2], 5);
            check(f_mism[0] + f_mism[1] + f_mism[2] == 0, "R2 burst bytes",
                  f_mism[0] + f_mism[1] + f_mism[2], 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_plain();
        t_truncate();
        t_minimum();
        t_runt();
        t_strip();
        t_fcs();
        t_enable();
        t_latch();
        t_burst();
        check(partial_n == 0, "R11 full middle beats", partial_n, 0);
        check(shape_n == 0, "R11 keep shape", shape_n, 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule